// File: doc/BRIEF.md
# Asynchronous Static Memory Cycle Sequencer

This block lets a synchronous host reach an external asynchronous static memory. The host raises a request with a direction bit, an address and, for a store, the data. While the controller is idle it accepts the request and latches these values. It then walks the memory bus through a fixed series of phases and raises a one-cycle completion pulse at the end. The memory bus has an address, active-low select, output-enable and write-enable strobes, and a shared bidirectional data bus.

Each phase length is a parameter counted in clock cycles, with a minimum of one. The phases are address setup, read access, write pulse with data and data hold.

A load works as follows. The controller holds the address and asserts select, then waits out the setup. It enables the memory outputs for the access window and captures the bus on the last edge of that window. The captured word stays on the host side until another load finishes.

A store works as follows. The controller holds the address and asserts select, then waits out the setup. It lowers write enable for one cycle before it drives any data. It then drives the word for the pulse interval with write enable still low. It raises write enable and keeps the word on the bus for the hold interval.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, all three bus strobes are high (inactive), busy and done are low, and the controller does not drive the data bus.
- R2: The controller accepts a request only when idle. A request raised while busy is ignored: it writes nothing, it adds no cycles to the current cycle, and busy falls on the cycle after done as usual.
- R3: The memory address equals the accepted request address from the first cycle after acceptance through the done cycle.
- R4: A load runs as follows. Select is low with output enable high for exactly T_ADDR_SETUP cycles. Output enable is then low for exactly T_READ_ACCESS cycles. Write enable stays high for the whole load.
- R5: The controller captures load data on the clock edge that ends the last output-enable-low cycle and presents it on rd_data in the done cycle. The value stays there unchanged until the next load completes, including through stores.
- R6: A store runs as follows. Select is low with write enable high for exactly T_ADDR_SETUP cycles. Write enable is then low for one lead cycle with no data driven. Write enable stays low for T_WRITE_PULSE more cycles while the store data is on the bus.
- R7: After write enable rises, the store data stays driven and select stays low for exactly T_DATA_HOLD cycles.
- R8: Output enable and write enable are never low together. The controller never drives the data bus while output enable is low.
- R9: Done is a single-cycle pulse at the end of every accepted request. Busy is high from the cycle after acceptance through the done cycle and low on the cycle after.
- R10: A word stored at an address is returned by a later load of that address. A load runs T_ADDR_SETUP+T_READ_ACCESS+1 busy cycles. A store runs T_ADDR_SETUP+T_WRITE_PULSE+T_DATA_HOLD+2 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled only when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last captured load data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |

## Verification
On every cycle, the assertions check these properties:
- output enable and write enable are mutually exclusive;
- the controller's driver stays off while output enable is low;
- write enable falls only under select;
- the address holds still through a cycle;
- done is a one-cycle pulse inside busy.

Some behaviour only the bench scenarios can show:
- the exact phase lengths;
- the gap with no data at the start of the write pulse;
- the data hold after write enable rises;
- that a load captures only after the full access delay;
- that requests raised while busy are ignored.

The bench shows these with an asynchronous memory model. The model returns corrupted data until output enable has been low for the access delay, and it stores on the rising edge of write enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_SETUP   = 3'd1,
      PH_ACCESS  = 3'd2,
      PH_WE_LEAD = 3'd3,
      PH_WDATA   = 3'd4,
      PH_WHOLD   = 3'd5,
      PH_FINISH  = 3'd6
   } phase_t;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   output logic             last
);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst)
         remain_q <= '0;
      else if (load)
         remain_q <= load_len - 1'b1;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign last = (remain_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int T_ADDR_SETUP  = 2,
   parameter int T_READ_ACCESS = 3,
   parameter int T_WRITE_PULSE = 2,
   parameter int T_DATA_HOLD   = 2,
   parameter int CNT_W         = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             req_write,
   input  logic             phase_last,
   output phase_t           phase,
   output logic             accept,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_len
);

   phase_t phase_q, phase_d;
   logic   store_q;

   always_comb begin
      phase_d = phase_q;
      accept  = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (req) begin
            phase_d = PH_SETUP;
            accept  = 1'b1;
         end
         PH_SETUP:   if (phase_last) phase_d = store_q ? PH_WE_LEAD : PH_ACCESS;
         PH_ACCESS:  if (phase_last) phase_d = PH_FINISH;
         PH_WE_LEAD: phase_d = PH_WDATA;
         PH_WDATA:   if (phase_last) phase_d = PH_WHOLD;
         PH_WHOLD:   if (phase_last) phase_d = PH_FINISH;
         PH_FINISH:  phase_d = PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (phase_d)
         PH_SETUP:  timer_len = CNT_W'(T_ADDR_SETUP);
         PH_ACCESS: timer_len = CNT_W'(T_READ_ACCESS);
         PH_WDATA:  timer_len = CNT_W'(T_WRITE_PULSE);
         PH_WHOLD:  timer_len = CNT_W'(T_DATA_HOLD);
         default:   timer_len = CNT_W'(1);
      endcase
   end

   assign timer_load = (phase_d != phase_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         store_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (accept) store_q <= req_write;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
   parameter int DATA_W = 8
) (
   input  logic              drive,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign dq[b] = drive ? wdata[b] : 1'bz;
   end

   assign rdata = dq;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int DATA_W        = 8,
   parameter int T_ADDR_SETUP  = 2,
   parameter int T_READ_ACCESS = 3,
   parameter int T_WRITE_PULSE = 2,
   parameter int T_DATA_HOLD   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int T_MAX = int'(max4(T_ADDR_SETUP, T_READ_ACCESS, T_WRITE_PULSE, T_DATA_HOLD));
   localparam int CNT_W = $clog2(T_MAX + 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_cycle_ctrl: bus widths must be at least 1");
   end
   if (T_ADDR_SETUP < 1 || T_READ_ACCESS < 1 || T_WRITE_PULSE < 1 || T_DATA_HOLD < 1) begin : g_bad_timing
      $error("sram_cycle_ctrl: every timing interval must be at least one cycle");
   end

   phase_t            phase;
   logic              accept;
   logic              timer_load;
   logic [CNT_W-1:0]  timer_len;
   logic              phase_last;
   logic              drv_en;
   logic              capture;
   logic [DATA_W-1:0] bus_in;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   sram_seq_fsm #(
      .T_ADDR_SETUP (T_ADDR_SETUP),
      .T_READ_ACCESS(T_READ_ACCESS),
      .T_WRITE_PULSE(T_WRITE_PULSE),
      .T_DATA_HOLD  (T_DATA_HOLD),
      .CNT_W        (CNT_W)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .req_write (req_write),
      .phase_last(phase_last),
      .phase     (phase),
      .accept    (accept),
      .timer_load(timer_load),
      .timer_len (timer_len)
   );

   sram_phase_timer #(
      .CNT_W(CNT_W)
   ) timer_i (
      .clk     (clk),
      .rst     (rst),
      .load    (timer_load),
      .load_len(timer_len),
      .last    (phase_last)
   );

   assign drv_en = (phase == PH_WDATA) || (phase == PH_WHOLD);

   sram_dq_port #(
      .DATA_W(DATA_W)
   ) dq_i (
      .drive(drv_en),
      .wdata(wdata_q),
      .rdata(bus_in),
      .dq   (mem_dq)
   );

   assign capture = (phase == PH_ACCESS) && phase_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= bus_in;
      end
   end

   assign mem_addr  = addr_q;
   assign mem_sel_n = (phase == PH_IDLE) || (phase == PH_FINISH);
   assign mem_oe_n  = (phase != PH_ACCESS);
   assign mem_we_n  = !((phase == PH_WE_LEAD) || (phase == PH_WDATA));
   assign busy      = (phase != PH_IDLE);
   assign done      = (phase == PH_FINISH);
   assign rd_data   = rdata_q;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sel_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              drv_en
);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n));

   assert_no_drive_on_oe_R8: assert property (@(posedge clk) disable iff (rst)
      drv_en |-> mem_oe_n);

   assert_we_under_sel_R6: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> !mem_sel_n);

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(mem_addr));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);

   assert_busy_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> busy);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (mem_sel_n && mem_oe_n && mem_we_n && !drv_en));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
   .ADDR_W(ADDR_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .busy     (busy),
   .done     (done),
   .mem_addr (mem_addr),
   .mem_sel_n(mem_sel_n),
   .mem_oe_n (mem_oe_n),
   .mem_we_n (mem_we_n),
   .drv_en   (drv_en)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int TA = 2;
   localparam int TC = 3;
   localparam int TP = 2;
   localparam int TH = 2;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy, done;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_sel_n, mem_oe_n, mem_we_n;
   wire  [DW-1:0] mem_dq;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mem   [DEPTH];
   logic [DW-1:0] shadow[DEPTH];
   int            oe_cycles = 0;
   logic [DW-1:0] last_read = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_cycle_ctrl #(
      .ADDR_W(AW), .DATA_W(DW),
      .T_ADDR_SETUP(TA), .T_READ_ACCESS(TC),
      .T_WRITE_PULSE(TP), .T_DATA_HOLD(TH)
   ) dut_i (
      .clk(clk), .rst(rst), .req(req), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
   );

   // asynchronous memory model: data valid only after the access delay
   always @(posedge clk) begin
      if (!mem_sel_n && !mem_oe_n) oe_cycles <= oe_cycles + 1;
      else oe_cycles <= 0;
   end
   assign mem_dq = (!mem_sel_n && !mem_oe_n && mem_we_n)
                   ? ((oe_cycles >= TC-1) ? mem[mem_addr] : ~mem[mem_addr]) : 'z;
   always @(posedge mem_we_n) begin
      if (!mem_sel_n) mem[mem_addr] = mem_dq;
   end

   task automatic check(input bit ok, input string req_tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
      end
   endtask

   // one request; sweeps all cycles up to done; stray=1 raises a second request while busy
   task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit stray);
      int total, bad_seq, bad_addr, bad_data;
      bit exp_sel, exp_oe, exp_we, exp_drv;
      total = wr ? (TA + TP + TH + 2) : (TA + TC + 1);
      bad_seq = 0; bad_addr = 0; bad_data = 0;
      @(negedge clk);
      req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      for (int k = 1; k <= total; k++) begin
         @(negedge clk);
         if (k == 1) req = 1'b0;
         if (stray && k == 2) begin
            req = 1'b1; req_write = 1'b1; req_addr = a ^ 4'h9; req_wdata = 8'hAA;
         end
         exp_sel = (k < total);
         exp_oe = 1'b0; exp_we = 1'b0; exp_drv = 1'b0;
         if (wr) begin
            exp_we  = (k > TA) && (k <= TA + 1 + TP);
            exp_drv = (k > TA + 1) && (k < total);
         end else begin
            exp_oe = (k > TA) && (k <= TA + TC);
         end
         if (mem_sel_n != !exp_sel || mem_oe_n != !exp_oe || mem_we_n != !exp_we
             || busy != 1'b1 || done != (k == total)) bad_seq++;
         if (mem_addr != a) bad_addr++;
         if (exp_drv && mem_dq != d) bad_data++;
         if (k == total) req = 1'b0;
      end
      if (wr) begin
         check(bad_seq == 0, "R6", "store strobe/busy/done sequence mismatches", bad_seq, 0);
         check(bad_data == 0, "R7", "store data driven through pulse and hold mismatches", bad_data, 0);
         shadow[a] = d;
         check(rd_data == last_read, "R5", "rd_data held across store", rd_data, last_read);
      end else begin
         check(bad_seq == 0, "R4", "load strobe/busy/done sequence mismatches", bad_seq, 0);
         check(rd_data == shadow[a], "R10", "load data", rd_data, shadow[a]);
         last_read = shadow[a];
      end
      check(bad_addr == 0, "R3", "address changes during cycle", bad_addr, 0);
      @(negedge clk);
      check(!busy && !done, "R9", "busy/done after done cycle", {busy, done}, 0);
      if (stray) begin
         check(mem_sel_n && !busy, "R2", "stray request not accepted", {mem_sel_n, busy}, 2);
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = 8'h5A;
         shadow[i] = 8'h5A;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(mem_sel_n && mem_oe_n && mem_we_n && !busy && !done, "R1", "reset strobes/busy/done",
            {mem_sel_n, mem_oe_n, mem_we_n, busy, done}, 5'b11100);
      check(rd_data == '0, "R1", "reset rd_data", rd_data, 0);

      for (int a = 0; a < DEPTH; a++) run_op(1'b1, AW'(a), DW'(a * 37 + 5), 1'b0);
      for (int a = 0; a < DEPTH; a++) run_op(1'b0, AW'(a), '0, 1'b0);
      for (int a = DEPTH - 1; a >= 0; a--) run_op(1'b1, AW'(a), DW'(a * 11 + 200), 1'b0);
      for (int a = 0; a < DEPTH; a += 3) run_op(1'b0, AW'(a), '0, 1'b0);

      // request raised while busy must be ignored; target a^9 keeps its value
      run_op(1'b1, 4'h3, 8'h3C, 1'b1);
      run_op(1'b0, 4'h3 ^ 4'h9, '0, 1'b0);
      run_op(1'b0, 4'h3, '0, 1'b1);
      run_op(1'b0, 4'h3 ^ 4'h9, '0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule